// File: doc/BRIEF.md
# Vectored Interrupt Qualification Unit

This block keeps one pending bit for each interrupt line of a core. A line update strobe carries a line index and a level. The bit for that line follows the level, and an index past the last line changes nothing. The block holds a local enable mask and a vector spacing field, loaded together through a configuration strobe. Each cycle it forms the enabled pending set, which is the pending bits ANDed with the mask. An interrupt qualifies only when the global enable is set, the core is not in debug state and the enabled pending set is nonzero. The highest numbered enabled pending line wins.

The winning line selects a vectored handler address: entry base + (CODE_BASE + line) × spacing. The spacing is 4 × 2^vs bytes. When the spacing field is zero, every line goes to the entry base. A two-state machine registers the request. In `VQ_IDLE` the request is low. The transition *qualify* moves to `VQ_TAKE`, where the request is high. The transition *disqualify* moves back to `VQ_IDLE`. The vector number and target PC are registered in the same cycle as the state, so they are valid whenever the request is high. A separate wake indication reports any enabled pending line. It ignores the global enable and the debug state, so an idle core can be woken.

Top module: `vec_irq_qual`

## Requirements
- R1: A strobe with `set_idx` below NLINES (13) sets pending bit `set_idx` when `set_level` is 1 and clears it when `set_level` is 0. The new value shows on `pend_o` one cycle after the strobe.
- R2: A strobe with `set_idx` of NLINES or more leaves `pend_o` unchanged.
- R3: `take_req` is high only in the cycle after one in which `glb_ie`=1, `dbg_active`=0 and (pending AND mask) is nonzero. It stays high while these conditions hold.
- R4: While `take_req` is high, `vec_num` is the highest set bit index of the enabled pending set from the previous cycle.
- R5: While `take_req` is high, `target_pc` = entry_base + (64 + vec_num) × (4 << vs) when vs ≠ 0, and `target_pc` = entry_base when vs = 0.
- R6: `has_work` is high exactly when (pending AND mask) is nonzero, whatever the values of `glb_ie` and `dbg_active`.
- R7: After reset, `pend_o`, the mask and the spacing field are 0, and `take_req` and `has_work` are 0.
- R8: A `cfg_load` strobe captures `cfg_lie` and `cfg_vs`. They take effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_valid | input | 1 | Line update strobe |
| set_idx | input | 5 | Line index of the update |
| set_level | input | 1 | New level of the line |
| cfg_load | input | 1 | Loads the mask and spacing field |
| cfg_lie | input | 13 | Local enable mask value |
| cfg_vs | input | 3 | Vector spacing exponent value |
| glb_ie | input | 1 | Global interrupt enable |
| dbg_active | input | 1 | Core is in debug state |
| entry_base | input | 32 | Exception entry base address |
| pend_o | output | 13 | Pending field |
| take_req | output | 1 | Registered take-interrupt request |
| vec_num | output | 4 | Winning line number |
| target_pc | output | 32 | Vectored handler address |
| has_work | output | 1 | Wake-from-idle indication |

## Verification
The assertions check these rules on every cycle:
- an out-of-range strobe leaves the pending field unchanged;
- a request never appears without a qualifying previous cycle;
- the reported vector is pending and enabled, with no higher enabled line;
- with a zero spacing field the handler address equals the base;
- a request implies the wake flag was up.

Only the bench scenarios can show the full address arithmetic for every line and spacing value. They also show that the mask and debug state block or shape the choice among several lines, and that configuration loads take effect one cycle later.

// File: rtl/vq_pkg.sv
package vq_pkg;
    typedef enum logic [0:0] {
        VQ_IDLE = 1'b0,
        VQ_TAKE = 1'b1
    } vq_state_e;
endpackage

// File: rtl/vq_pend_reg.sv
module vq_pend_reg #(
    parameter int NLINES = 13,
    parameter int IDX_W  = 5,
    parameter int VS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_valid,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic              set_level,
    input  logic              cfg_load,
    input  logic [NLINES-1:0] cfg_lie,
    input  logic [VS_W-1:0]   cfg_vs,
    output logic [NLINES-1:0] pend,
    output logic [NLINES-1:0] lie,
    output logic [VS_W-1:0]   vs
);
    // one flop per line; an index past the last line matches no flop
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[g] <= 1'b0;
            end else if (set_valid && (set_idx == IDX_W'(g))) begin
                pend[g] <= set_level;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lie <= '0;
            vs  <= '0;
        end else if (cfg_load) begin
            lie <= cfg_lie;
            vs  <= cfg_vs;
        end
    end

    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && (int'(set_idx) >= NLINES)) |=> $stable(pend)); // R2
endmodule

// File: rtl/vq_prio_enc.sv
module vq_prio_enc #(
    parameter int NLINES = 13,
    parameter int VEC_W  = 4
) (
    input  logic [NLINES-1:0] req,
    output logic [VEC_W-1:0]  win,
    output logic              any
);
    // ascending scan: the last set bit seen is the highest one
    always_comb begin
        win = '0;
        any = 1'b0;
        for (int i = 0; i < NLINES; i++) begin
            if (req[i]) begin
                win = VEC_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vq_vec_calc.sv
module vq_vec_calc #(
    parameter int ADDR_W    = 32,
    parameter int VEC_W     = 4,
    parameter int VS_W      = 3,
    parameter int CODE_BASE = 64
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VEC_W-1:0]  vec,
    input  logic [VS_W-1:0]   vs,
    output logic [ADDR_W-1:0] pc
);
    localparam int SH_W = VS_W + 2;

    logic [ADDR_W-1:0] units;
    logic [SH_W-1:0]   shamt;

    always_comb begin
        units = ADDR_W'(CODE_BASE) + ADDR_W'(vec);
        shamt = SH_W'(vs) + SH_W'(2);
        if (vs == '0) begin
            pc = base;
        end else begin
            pc = base + (units << shamt);
        end
    end
endmodule

// File: rtl/vec_irq_qual.sv
module vec_irq_qual #(
    parameter int NLINES    = 13,
    parameter int IDX_W     = 5,
    parameter int VS_W      = 3,
    parameter int ADDR_W    = 32,
    parameter int CODE_BASE = 64,
    parameter int VEC_W     = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_valid,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic              set_level,
    input  logic              cfg_load,
    input  logic [NLINES-1:0] cfg_lie,
    input  logic [VS_W-1:0]   cfg_vs,
    input  logic              glb_ie,
    input  logic              dbg_active,
    input  logic [ADDR_W-1:0] entry_base,
    output logic [NLINES-1:0] pend_o,
    output logic              take_req,
    output logic [VEC_W-1:0]  vec_num,
    output logic [ADDR_W-1:0] target_pc,
    output logic              has_work
);
    import vq_pkg::*;

    logic [NLINES-1:0] pend, lie, masked;
    logic [VS_W-1:0]   vs;
    logic [VEC_W-1:0]  win;
    logic              any_masked;
    logic [ADDR_W-1:0] pc_calc;
    logic              qualify;
    vq_state_e         state, state_nx;

    vq_pend_reg #(.NLINES(NLINES), .IDX_W(IDX_W), .VS_W(VS_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_idx(set_idx),
        .set_level(set_level), .cfg_load(cfg_load), .cfg_lie(cfg_lie),
        .cfg_vs(cfg_vs), .pend(pend), .lie(lie), .vs(vs)
    );

    assign masked = pend & lie;

    vq_prio_enc #(.NLINES(NLINES), .VEC_W(VEC_W)) u_prio (
        .req(masked), .win(win), .any(any_masked)
    );

    vq_vec_calc #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .VS_W(VS_W),
                  .CODE_BASE(CODE_BASE)) u_calc (
        .base(entry_base), .vec(win), .vs(vs), .pc(pc_calc)
    );

    assign qualify  = glb_ie && !dbg_active && any_masked;
    assign has_work = any_masked;
    assign pend_o   = pend;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= VQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            VQ_IDLE: if (qualify)  state_nx = VQ_TAKE;
            VQ_TAKE: if (!qualify) state_nx = VQ_IDLE;
            default: state_nx = VQ_IDLE;
        endcase
    end

    // outputs, registered alongside the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_num   <= '0;
            target_pc <= '0;
        end else if (qualify) begin
            vec_num   <= win;
            target_pc <= pc_calc;
        end
    end

    assign take_req = (state == VQ_TAKE);

    AST_TAKE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> $past(glb_ie && !dbg_active && (masked != '0))); // R3
    AST_VEC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> ((($past(masked) >> vec_num) & NLINES'(1)) != '0)); // R4
    AST_VEC_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> ((($past(masked) >> vec_num) >> 1) == '0)); // R4
    AST_FLAT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && ($past(vs) == '0)) |-> (target_pc == $past(entry_base))); // R5
    AST_WORK_BEFORE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> $past(has_work)); // R6
endmodule

// File: tb/vec_irq_qual_tb_top.sv
module vec_irq_qual_tb_top;
    localparam int NL = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_valid = 1'b0;
    logic [4:0]  set_idx = '0;
    logic        set_level = 1'b0;
    logic        cfg_load = 1'b0;
    logic [12:0] cfg_lie = '0;
    logic [2:0]  cfg_vs = '0;
    logic        glb_ie = 1'b0;
    logic        dbg_active = 1'b0;
    logic [31:0] entry_base = 32'h1C00_0000;
    logic [12:0] pend_o;
    logic        take_req;
    logic [3:0]  vec_num;
    logic [31:0] target_pc;
    logic        has_work;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    vec_irq_qual dut_i (
        .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_idx(set_idx),
        .set_level(set_level), .cfg_load(cfg_load), .cfg_lie(cfg_lie),
        .cfg_vs(cfg_vs), .glb_ie(glb_ie), .dbg_active(dbg_active),
        .entry_base(entry_base), .pend_o(pend_o), .take_req(take_req),
        .vec_num(vec_num), .target_pc(target_pc), .has_work(has_work)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_line(input int idx, input bit lvl);
        set_valid = 1'b1; set_idx = 5'(idx); set_level = lvl;
        tick();
        set_valid = 1'b0;
    endtask

    task automatic load_cfg(input logic [12:0] m, input logic [2:0] v);
        cfg_load = 1'b1; cfg_lie = m; cfg_vs = v;
        tick();
        cfg_load = 1'b0;
    endtask

    function automatic logic [31:0] exp_pc(input int v, input int vs);
        if (vs == 0) return entry_base;
        return entry_base + 32'((64 + v) * ((1 << vs) * 4));
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [12:0] snap;
        repeat (3) tick();
        // R7: reset state
        chk(pend_o == 0, "R7", pend_o, 0);
        chk(take_req == 0, "R7", take_req, 0);
        chk(has_work == 0, "R7", has_work, 0);
        rst_n = 1'b1;
        tick();
        // R7: mask is zero after reset, so a pending line gives no work
        set_line(5, 1'b1);
        chk(pend_o == 13'h0020, "R1", pend_o, 13'h0020);
        chk(has_work == 0, "R7", has_work, 0);
        set_line(5, 1'b0);
        chk(pend_o == 0, "R1", pend_o, 0);

        // R8: configuration takes effect the cycle after the load
        glb_ie = 1'b1;
        set_line(3, 1'b1);
        load_cfg(13'h1FFF, 3'd0);
        chk(has_work == 1, "R8", has_work, 1);
        tick();
        chk(take_req == 1, "R8", take_req, 1);
        set_line(3, 1'b0);
        tick();
        chk(take_req == 0, "R3", take_req, 0);

        // R4 R5: sweep all lines and all spacing values, one line pending
        for (int vs = 0; vs < 8; vs++) begin
            load_cfg(13'h1FFF, 3'(vs));
            for (int ln = 0; ln < NL; ln++) begin
                set_line(ln, 1'b1);
                tick();
                chk(take_req == 1, "R3", take_req, 1);
                chk(vec_num == 4'(ln), "R4", vec_num, ln);
                chk(target_pc == exp_pc(ln, vs), "R5", target_pc, exp_pc(ln, vs));
                set_line(ln, 1'b0);
                tick();
            end
        end

        // R2: out-of-range indices leave pending unchanged
        set_line(7, 1'b1);
        snap = pend_o;
        for (int ix = NL; ix < 32; ix++) begin
            set_line(ix, 1'b1);
            chk(pend_o == snap, "R2", pend_o, snap);
        end

        // R4: the highest of several wins; the mask hides higher lines
        load_cfg(13'h1FFF, 3'd2);
        set_line(2, 1'b1);
        set_line(11, 1'b1);
        tick();
        chk(vec_num == 4'd11, "R4", vec_num, 11);
        chk(target_pc == exp_pc(11, 2), "R5", target_pc, exp_pc(11, 2));
        load_cfg(13'h00FF, 3'd2);
        tick();
        chk(vec_num == 4'd7, "R4", vec_num, 7);

        // R3 R6: debug state and the global enable block the request only
        dbg_active = 1'b1;
        tick(); tick();
        chk(take_req == 0, "R3", take_req, 0);
        chk(has_work == 1, "R6", has_work, 1);
        dbg_active = 1'b0;
        glb_ie = 1'b0;
        tick(); tick();
        chk(take_req == 0, "R3", take_req, 0);
        chk(has_work == 1, "R6", has_work, 1);
        glb_ie = 1'b1;
        tick();
        chk(take_req == 1, "R3", take_req, 1);

        // R6: nothing enabled means no work
        load_cfg(13'h0000, 3'd2);
        chk(has_work == 0, "R6", has_work, 0);
        tick();
        chk(take_req == 0, "R3", take_req, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule